// File: doc/BRIEF.md
# Stop-Mode Wake-Up Stabilization Timer

This block paces the return of a small controller from its lowest-power halt. While halted, the oscillator is off, and the core clock must stay blocked until the restarted oscillator has had time to settle. The block holds an 8-bit prescaler that feeds an 8-bit timer. When an external interrupt ends the halt, the prescaler counts oscillator cycles, and the timer steps once each time the prescaler wraps. The core clock enable is opened only when the timer underflows.

By default, the wake-up loads fixed counts into both stages, giving a wait of 512 oscillator cycles. Software can set an inhibit bit before halting. The counts it wrote earlier are then kept, and the wait becomes (prescaler+1)×(timer+1) cycles. While the core runs, register writes load the counters directly. While halted or waking, the register port is ignored, because the core is not clocked.

Top module: `wkstab_top`

## Requirements
- R1: After synchronous reset, `cpu_clk_en` is 1, `wake_done` is 0 and the inhibit bit is 0, so the first wake-up uses the automatic counts.
- R2: A `stop_req` sampled high while running drops `cpu_clk_en` on the next cycle. The enable stays low for as long as the block remains halted.
- R3: Only `ext_irq` ends the halt. An `ext_irq` while running has no effect. A `stop_req` while halted or waking has no effect.
- R4: With the inhibit bit at 0, wake-up loads the timer with 0x01 and the prescaler with 0xFF. `cpu_clk_en` then rises 512 cycles after the edge that samples `ext_irq`.
- R5: The inhibit bit is bit 0 of the control register at address 0x10. The other bits of that register are ignored.
- R6: With the inhibit bit at 1, the values last written to the prescaler (address 0x11) and the timer (address 0x12) set the wait. The wait is (P+1)×(T+1) cycles after the edge that samples `ext_irq`. The prescaler reloads its stored value each time it wraps from 0, and the timer steps down on each wrap.
- R7: `cpu_clk_en` stays low until the timer underflows. `wake_done` is high for exactly the one cycle in which `cpu_clk_en` first returns high.
- R8: Register writes made while halted or waking change neither the counters nor the inhibit bit.
- R9: A register write presented in the same cycle as `stop_req` still takes effect, and it governs the following wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| stop_req | input | 1 | Request to enter the halt |
| ext_irq | input | 1 | External interrupt that ends the halt |
| cpu_clk_en | output | 1 | Core clock enable, high while running |
| wake_done | output | 1 | One-cycle pulse when the core clock reopens |

## Verification
Two coincidences are provoked. The first is a timer write landing in the same cycle as the halt request. It is judged by whether the next wait length follows the newly written count. The second is a halt request arriving while the wake-up count is already running. It is judged by the wait length staying unchanged and the enable opening normally. Wait lengths are measured at the ports as whole cycles from the interrupt-sampling edge to the enable rise, and each is compared with the product computed in the bench from the written counts.

// File: rtl/wkstab_pkg.sv
package wkstab_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_PRE  = 8'h11;
    localparam logic [ADDR_W-1:0] ADDR_TMR  = 8'h12;

    localparam logic [CNT_W-1:0] AUTO_PRE = 8'hFF;
    localparam logic [CNT_W-1:0] AUTO_TMR = 8'h01;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAKE = 2'd2
    } wk_state_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  data;
    } bus_wr_t;

    typedef struct packed {
        logic             pre_ld;
        logic             tmr_ld;
        logic [CNT_W-1:0] val;
    } sw_load_t;

    function automatic logic addr_hit(bus_wr_t w, logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/wkstab_regs.sv
module wkstab_regs
    import wkstab_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_wr_t  wr,
    input  logic     accept,
    output logic     inhibit,
    output sw_load_t sw_ld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            inhibit <= 1'b0;
        end else if (accept && addr_hit(wr, ADDR_CTRL)) begin
            inhibit <= wr.data[0];
        end
    end

    always_comb begin
        sw_ld.pre_ld = accept && addr_hit(wr, ADDR_PRE);
        sw_ld.tmr_ld = accept && addr_hit(wr, ADDR_TMR);
        sw_ld.val    = wr.data;
    end

    // R8: control bit frozen while the core is not running
    p_ctrl_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(inhibit));

endmodule

// File: rtl/wkstab_chain.sv
module wkstab_chain
    import wkstab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sw_load_t         sw_ld,
    input  logic             auto_ld,
    input  logic             count_en,
    output logic             underflow
);

    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] tmr_q;

    logic pre_wrap;
    assign pre_wrap  = count_en && (pre_q == '0);
    assign underflow = pre_wrap && (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            rld_q <= '0;
            tmr_q <= '0;
        end else if (auto_ld) begin
            pre_q <= AUTO_PRE;
            rld_q <= AUTO_PRE;
            tmr_q <= AUTO_TMR;
        end else if (count_en) begin
            if (pre_wrap) begin
                pre_q <= rld_q;
                tmr_q <= tmr_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end else begin
            if (sw_ld.pre_ld) begin
                pre_q <= sw_ld.val;
                rld_q <= sw_ld.val;
            end
            if (sw_ld.tmr_ld) begin
                tmr_q <= sw_ld.val;
            end
        end
    end

    // R4: automatic load places the fixed counts
    p_auto_values_r4: assert property (@(posedge clk) disable iff (rst)
        auto_ld |=> (pre_q == AUTO_PRE && tmr_q == AUTO_TMR));

    // R6: timer steps down by one on each prescaler wrap
    p_timer_step_r6: assert property (@(posedge clk) disable iff (rst)
        (count_en && pre_q == '0 && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));

    // R6: prescaler restarts from its stored value after a wrap
    p_pre_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (count_en && pre_q == '0) |=> (pre_q == rld_q));

    // R8: counters hold while halted unless the wake-up load fires
    p_hold_in_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !auto_ld && !sw_ld.pre_ld && !sw_ld.tmr_ld)
        |=> ($stable(pre_q) && $stable(tmr_q)));

endmodule

// File: rtl/wkstab_seq.sv
module wkstab_seq
    import wkstab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic ext_irq,
    input  logic inhibit,
    input  logic underflow,
    output logic accept,
    output logic auto_ld,
    output logic count_en,
    output logic cpu_clk_en,
    output logic wake_done
);

    wk_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (stop_req)  st_d = ST_STOP;
            ST_STOP: if (ext_irq)   st_d = ST_WAKE;
            ST_WAKE: if (underflow) st_d = ST_RUN;
            default:                st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_RUN;
            wake_done <= 1'b0;
        end else begin
            st_q      <= st_d;
            wake_done <= (st_q == ST_WAKE) && underflow;
        end
    end

    assign accept     = (st_q == ST_RUN);
    assign count_en   = (st_q == ST_WAKE);
    assign auto_ld    = (st_q == ST_STOP) && ext_irq && !inhibit;
    assign cpu_clk_en = (st_q == ST_RUN);

    // R2: halt request closes the clock next cycle
    p_stop_gates_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && stop_req) |=> !cpu_clk_en);

    // R3: without an interrupt the halt persists
    p_hold_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && !ext_irq) |=> (st_q == ST_STOP));

    // R7: gate stays closed until the timer underflows
    p_gate_until_uf_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAKE && !underflow) |=> !cpu_clk_en);

    // R7: completion pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> !wake_done);

    // R7: completion pulse coincides with the enable rise
    p_done_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> wake_done);

endmodule

// File: rtl/wkstab_top.sv
module wkstab_top
    import wkstab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              stop_req,
    input  logic              ext_irq,
    output logic              cpu_clk_en,
    output logic              wake_done
);

    bus_wr_t  wr;
    sw_load_t sw_ld;
    logic     inhibit;
    logic     accept;
    logic     auto_ld;
    logic     count_en;
    logic     underflow;

    assign wr = '{en: bus_wr_en, addr: bus_addr, data: bus_wdata};

    wkstab_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .accept  (accept),
        .inhibit (inhibit),
        .sw_ld   (sw_ld)
    );

    wkstab_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .sw_ld     (sw_ld),
        .auto_ld   (auto_ld),
        .count_en  (count_en),
        .underflow (underflow)
    );

    wkstab_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (stop_req),
        .ext_irq    (ext_irq),
        .inhibit    (inhibit),
        .underflow  (underflow),
        .accept     (accept),
        .auto_ld    (auto_ld),
        .count_en   (count_en),
        .cpu_clk_en (cpu_clk_en),
        .wake_done  (wake_done)
    );

endmodule

// File: tb/wkstab_top_tb.sv
module wkstab_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr_en;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       stop_req;
    logic       ext_irq;
    logic       cpu_clk_en;
    logic       wake_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wkstab_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_wr_en  (bus_wr_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .stop_req   (stop_req),
        .ext_irq    (ext_irq),
        .cpu_clk_en (cpu_clk_en),
        .wake_done  (wake_done)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  pre;
        logic [7:0]  tmr;
        logic [31:0] exp;
    } vec_t;

    // ctrl bit0 is inhibit; upper bits set on purpose (R5)
    localparam vec_t VECS [7] = '{
        '{8'hFE, 8'h05, 8'h03, 32'd512},
        '{8'hFF, 8'h00, 8'h00, 32'd1},
        '{8'h01, 8'h03, 8'h02, 32'd12},
        '{8'hFF, 8'h0F, 8'h00, 32'd16},
        '{8'h81, 8'h00, 8'h07, 32'd8},
        '{8'h01, 8'hFF, 8'h00, 32'd256},
        '{8'h00, 8'h00, 8'h00, 32'd512}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_stop(input string req);
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(cpu_clk_en == 1'b0, req, int'(cpu_clk_en), 0);
    endtask

    task automatic do_wake(input int exp, input string req, input bit poke_stop);
        int cnt;
        @(negedge clk);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        cnt = 0;
        while (cnt < 70000) begin
            @(negedge clk);
            cnt++;
            stop_req = poke_stop && cnt >= 2 && cnt < 5;
            if (cpu_clk_en) break;
        end
        stop_req = 1'b0;
        chk(cnt == exp, req, cnt, exp);
        chk(wake_done == 1'b1, "R7 pulse at rise", int'(wake_done), 1);
        @(negedge clk);
        chk(wake_done == 1'b0 && cpu_clk_en == 1'b1, "R7 pulse one cycle",
            int'({wake_done, cpu_clk_en}), 1);
    endtask

    initial begin
        rst = 1'b1; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
        stop_req = 1'b0; ext_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cpu_clk_en == 1'b1, "R1 enable after reset", int'(cpu_clk_en), 1);
        chk(wake_done == 1'b0, "R1 no pulse after reset", int'(wake_done), 0);

        // R3: interrupt while running does nothing
        ext_irq = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cpu_clk_en == 1'b1 && wake_done == 1'b0, "R3 irq in run",
                int'({cpu_clk_en, wake_done}), 2);
        end
        ext_irq = 1'b0;

        // R1/R4: first wake after reset uses the fixed counts
        do_stop("R2 stop gates");
        do_wake(512, "R1 R4 default wait", 1'b0);

        // Vector table: R4 R5 R6
        for (int v = 0; v < 7; v++) begin
            bus_write(8'h11, VECS[v].pre);
            bus_write(8'h12, VECS[v].tmr);
            bus_write(8'h10, VECS[v].ctrl);
            do_stop("R2 stop gates");
            do_wake(int'(VECS[v].exp), "R5 R6 wait length", 1'b0);
        end

        // R2 long halt, plus R3 repeated stop_req while halted
        bus_write(8'h10, 8'h01);
        bus_write(8'h11, 8'h02);
        bus_write(8'h12, 8'h01);
        do_stop("R2 stop gates");
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            stop_req = (i == 10);
            chk(cpu_clk_en == 1'b0, "R2 R3 stays halted", int'(cpu_clk_en), 0);
        end
        stop_req = 1'b0;
        // R8: writes while halted are ignored
        bus_write(8'h11, 8'h20);
        bus_write(8'h12, 8'h05);
        bus_write(8'h10, 8'h00);
        do_wake(6, "R8 writes in stop ignored", 1'b0);

        // R3: stop_req during the wake count has no effect
        bus_write(8'h11, 8'h03);
        bus_write(8'h12, 8'h03);
        do_stop("R2 stop gates");
        do_wake(16, "R3 stop in wake ignored", 1'b1);

        // R9: write in the same cycle as the halt request
        bus_write(8'h11, 8'h01);
        bus_write(8'h12, 8'h00);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h12; bus_wdata = 8'h03; stop_req = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; stop_req = 1'b0;
        chk(cpu_clk_en == 1'b0, "R9 stop with write", int'(cpu_clk_en), 0);
        do_wake(8, "R9 same-cycle write counts", 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule